// File: doc/BRIEF.md
# Watchdog Timer with Timeout Action Dispatch

This block is a watchdog down-counter that advances once per pulse of a 1 MHz tick enable. If software stops servicing it, the counter reaches zero and the block raises one configurable timeout action. The action is one of four: reset only the processor, reset a chosen subset of SoC controllers, reset the whole system, or raise no reset at all.

A timeout can also latch a request to boot from the alternate boot region. It can also drive a timed pulse on an external pin. That pin's width, drive mode and polarity are all programmable, and the pad is modelled as a data line plus an output enable.

Software programs the block through a simple write-only port. It sets the reload value, enables the timer and services it by writing a key value to a restart address. Reset outputs are single-clock pulses that a downstream reset controller stretches and synchronises. After each expiry the counter reloads itself and keeps running.

Top module: `wdt_dispatch`

## Requirements
- R1: After rst_ni is released, every reset output, alt_boot_o, timeout_o, ext_oe_o and ext_pin_o are low. The timer is disabled, the reset type is full-system and the peripheral mask is all zero.
- R2: Write address 0 sets the reload value N, and bit 0 of address 2 enables the timer. With tick_i held high, the first timeout appears N+1 clocks after the enable write. The counter then reloads and times out again every N+1 ticks.
- R3: The counter moves only in clocks where tick_i is high. With tick_i low no timeout ever occurs, and with single tick pulses the timeout follows the (N+1)-th tick.
- R4: A write of 0x5A5AC3C3 to address 1 reloads the counter from N in that clock. A write of any other value to address 1 is ignored.
- R5: Bits [1:0] of address 3 select the reset type: 0 processor, 1 SoC subset, 2 full system, 3 none. With type 0, a timeout pulses cpu_rst_o for one clock and no other reset.
- R6: With type 1, a timeout drives soc_rst_o for one clock with exactly the 64-bit mask. Address 5 holds mask bits 31:0 and address 6 holds bits 63:32. Unmasked controllers see no reset.
- R7: With type 2, which is the value after reset, a timeout pulses sys_rst_o for one clock and no other reset.
- R8: With type 3, a timeout raises no reset output, but timeout_o is still set and the external pulse is still emitted.
- R9: If bit 2 of address 3 is set, a timeout sets alt_boot_o. It then stays set until rst_ni.
- R10: If bit 3 of address 3 is set, a timeout emits an external pulse lasting W ticks, where W is written to address 4. A W of zero gives one tick. With bit 3 clear, no pulse is emitted.
- R11: With bit 4 of address 3 clear, the pin is open-drain. ext_oe_o is high only during the pulse, and ext_pin_o is then low.
- R12: With bit 4 set, the pin is push-pull and ext_oe_o stays high. The pulse is active-high only if bit 5 is also set, and active-low otherwise. Bit 5 without bit 4 leaves open-drain low pulses.
- R13: timeout_o is sticky after a timeout. It is cleared by a valid restart or by disabling the timer, but not by a wrong restart value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 1 MHz time-base enable, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| cpu_rst_o | output | 1 | Processor reset pulse |
| soc_rst_o | output | 64 | Per-controller reset pulses, masked |
| sys_rst_o | output | 1 | Full-system reset pulse |
| alt_boot_o | output | 1 | Latched alternate-boot request |
| timeout_o | output | 1 | Sticky timeout flag |
| ext_pin_o | output | 1 | External pin data |
| ext_oe_o | output | 1 | External pin output enable |

## Verification
The embedded properties check several rules on every cycle. No more than one reset class fires at a time, and SoC resets never reach a controller outside the mask held the cycle before. Type none stays silent, the boot request stays latched, and a restart prevents an expiry in the next clock. In open-drain mode the enabled pin is never driven high. Other behaviour only shows through the directed scenarios: the exact N+1 tick spacing, the effect of gated ticks, rejection of wrong restart keys, pulse lengths including the zero-width case, and the idle and active pin levels in each drive mode.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam int unsigned A_RELOAD  = 0;
  localparam int unsigned A_RESTART = 1;
  localparam int unsigned A_ENABLE  = 2;
  localparam int unsigned A_CTRL    = 3;
  localparam int unsigned A_PULSE   = 4;
  localparam int unsigned A_MASK0   = 5;

  typedef enum logic [1:0] {
    RT_CPU  = 2'd0,
    RT_SOC  = 2'd1,
    RT_SYS  = 2'd2,
    RT_NONE = 2'd3
  } rst_type_e;

  typedef struct packed {
    logic      act_high;
    logic      push_pull;
    logic      ext_en;
    logic      alt_boot;
    rst_type_e rst_type;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{act_high: 1'b0, push_pull: 1'b0, ext_en: 1'b0,
                                 alt_boot: 1'b0, rst_type: RT_SYS};
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned     DATA_W      = 32,
  parameter int unsigned     CNT_W       = 32,
  parameter int unsigned     PW_W        = 16,
  parameter int unsigned     MASK_WORDS  = 2,
  parameter logic [CNT_W-1:0] RELOAD_RST = CNT_W'(1000),
  parameter logic [DATA_W-1:0] RESTART_KEY = 32'h5A5A_C3C3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic [CNT_W-1:0]             reload_o,
  output logic                         en_o,
  output ctrl_t                        ctrl_o,
  output logic [PW_W-1:0]              pulse_w_o,
  output logic [MASK_WORDS*DATA_W-1:0] mask_o,
  output logic                         restart_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic [CNT_W-1:0]  reload_q;
  logic              en_q;
  ctrl_t             ctrl_q;
  logic [PW_W-1:0]   pw_q;
  logic [DATA_W-1:0] mask_q [MASK_WORDS];
  logic [MASK_WORDS-1:0] mask_hit;

  function automatic logic hit(input int unsigned a);
    return wr_en_i && (wr_addr_i == ADDR_W'(a));
  endfunction

  for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask
    assign mask_hit[w] = hit(A_MASK0 + w);
    assign mask_o[w*DATA_W +: DATA_W] = mask_q[w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= RELOAD_RST;
      en_q     <= 1'b0;
      ctrl_q   <= CTRL_RST;
      pw_q     <= '0;
      for (int w = 0; w < MASK_WORDS; w++) mask_q[w] <= '0;
    end else begin
      if (hit(A_RELOAD)) reload_q <= wr_data_i[CNT_W-1:0];
      if (hit(A_ENABLE)) en_q     <= wr_data_i[0];
      if (hit(A_CTRL))   ctrl_q   <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (hit(A_PULSE))  pw_q     <= wr_data_i[PW_W-1:0];
      for (int w = 0; w < MASK_WORDS; w++)
        if (mask_hit[w]) mask_q[w] <= wr_data_i;
    end
  end

  assign restart_o = hit(A_RESTART) && (wr_data_i == RESTART_KEY);
  assign reload_o  = reload_q;
  assign en_o      = en_q;
  assign ctrl_o    = ctrl_q;
  assign pulse_w_o = pw_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             evt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i || !en_i) begin
      cnt_q <= reload_i;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
    end
  end

  // a restart in the same clock wins over expiry
  assign evt_o = en_i && tick_i && !restart_i && (cnt_q == '0);

  // R4
  restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && en_i && reload_i != '0) |=> !evt_o);
endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
#(
  parameter int unsigned MW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_i,
  input  logic          en_i,
  input  logic          restart_i,
  input  ctrl_t         ctrl_i,
  input  logic [MW-1:0] mask_i,
  output logic          cpu_rst_o,
  output logic [MW-1:0] soc_rst_o,
  output logic          sys_rst_o,
  output logic          alt_boot_o,
  output logic          timeout_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_rst_o  <= 1'b0;
      soc_rst_o  <= '0;
      sys_rst_o  <= 1'b0;
      alt_boot_o <= 1'b0;
      timeout_o  <= 1'b0;
    end else begin
      cpu_rst_o  <= evt_i && (ctrl_i.rst_type == RT_CPU);
      soc_rst_o  <= (evt_i && (ctrl_i.rst_type == RT_SOC)) ? mask_i : '0;
      sys_rst_o  <= evt_i && (ctrl_i.rst_type == RT_SYS);
      alt_boot_o <= alt_boot_o || (evt_i && ctrl_i.alt_boot);
      if (restart_i || !en_i) timeout_o <= 1'b0;
      else if (evt_i)         timeout_o <= 1'b1;
    end
  end

  // R5
  one_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cpu_rst_o, |soc_rst_o, sys_rst_o}));
  // R6
  soc_in_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|soc_rst_o) |-> ((soc_rst_o & ~$past(mask_i)) == '0));
  // R8
  none_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && ctrl_i.rst_type == RT_NONE) |=> (!cpu_rst_o && !sys_rst_o && soc_rst_o == '0));
  // R9
  alt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_boot_o |=> alt_boot_o);
endmodule

// File: rtl/wdt_ext_pulse.sv
module wdt_ext_pulse #(
  parameter int unsigned PW_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            evt_i,
  input  logic            ext_en_i,
  input  logic            push_pull_i,
  input  logic            act_high_i,
  input  logic [PW_W-1:0] width_i,
  output logic            pin_o,
  output logic            oe_o
);
  logic [PW_W-1:0] left_q;
  logic            active;
  logic            high_pol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (evt_i && ext_en_i) begin
      left_q <= (width_i == '0) ? PW_W'(1) : width_i;
    end else if (tick_i && left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active   = (left_q != '0);
  // active-high only legal with push-pull drive
  assign high_pol = push_pull_i && act_high_i;

  always_comb begin
    if (!ext_en_i) begin
      oe_o  = 1'b0;
      pin_o = 1'b0;
    end else if (push_pull_i) begin
      oe_o  = 1'b1;
      pin_o = high_pol ? active : !active;
    end else begin
      oe_o  = active;
      pin_o = 1'b0;
    end
  end

  // R10
  pulse_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && ext_en_i) |=> (!ext_en_i || push_pull_i || oe_o));
  // R11
  od_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !push_pull_i) |-> !pin_o);
endmodule

// File: rtl/wdt_dispatch.sv
module wdt_dispatch
  import wdt_pkg::*;
#(
  parameter int unsigned       DATA_W      = 32,
  parameter int unsigned       CNT_W       = 32,
  parameter int unsigned       PW_W        = 16,
  parameter int unsigned       MASK_WORDS  = 2,
  parameter logic [CNT_W-1:0]  RELOAD_RST  = CNT_W'(1000),
  parameter logic [DATA_W-1:0] RESTART_KEY = 32'h5A5A_C3C3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tick_i,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic                         cpu_rst_o,
  output logic [MASK_WORDS*DATA_W-1:0] soc_rst_o,
  output logic                         sys_rst_o,
  output logic                         alt_boot_o,
  output logic                         timeout_o,
  output logic                         ext_pin_o,
  output logic                         ext_oe_o
);
  localparam int unsigned MW = MASK_WORDS * DATA_W;

  logic [CNT_W-1:0] reload;
  logic             en;
  ctrl_t            ctrl;
  logic [PW_W-1:0]  pulse_w;
  logic [MW-1:0]    mask;
  logic             restart;
  logic             evt;

  wdt_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PW_W(PW_W), .MASK_WORDS(MASK_WORDS),
    .RELOAD_RST(RELOAD_RST), .RESTART_KEY(RESTART_KEY)
  ) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .reload_o(reload), .en_o(en), .ctrl_o(ctrl), .pulse_w_o(pulse_w),
    .mask_o(mask), .restart_o(restart)
  );

  wdt_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i, .rst_ni, .tick_i, .en_i(en), .restart_i(restart),
    .reload_i(reload), .evt_o(evt)
  );

  wdt_action #(.MW(MW)) i_action (
    .clk_i, .rst_ni, .evt_i(evt), .en_i(en), .restart_i(restart),
    .ctrl_i(ctrl), .mask_i(mask),
    .cpu_rst_o, .soc_rst_o, .sys_rst_o, .alt_boot_o, .timeout_o
  );

  wdt_ext_pulse #(.PW_W(PW_W)) i_pulse (
    .clk_i, .rst_ni, .tick_i, .evt_i(evt),
    .ext_en_i(ctrl.ext_en), .push_pull_i(ctrl.push_pull), .act_high_i(ctrl.act_high),
    .width_i(pulse_w), .pin_o(ext_pin_o), .oe_o(ext_oe_o)
  );
endmodule

// File: tb/test_wdt_dispatch.sv
module test_wdt_dispatch;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] KEY = 32'h5A5A_C3C3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        cpu_rst, sys_rst, alt_boot, timeout, ext_pin, ext_oe;
  logic [63:0] soc_rst;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_dispatch i_wdt_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cpu_rst_o(cpu_rst), .soc_rst_o(soc_rst), .sys_rst_o(sys_rst),
    .alt_boot_o(alt_boot), .timeout_o(timeout),
    .ext_pin_o(ext_pin), .ext_oe_o(ext_oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl(input logic [1:0] ty, input logic alt,
                                       input logic ext, input logic pp, input logic ah);
    return {26'd0, ah, pp, ext, alt, ty};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_to_timeout(output int k);
    k = 0;
    while (!timeout && k < 2000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic pulse_len(input logic lvl, output int w);
    w = 0;
    while (ext_oe && ext_pin == lvl && w < 100) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic quiesce();
    wr(3'd2, 32'd0);
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cpu", 64'(cpu_rst), 64'd0);
    chk("R1 soc", soc_rst, 64'd0);
    chk("R1 sys", 64'(sys_rst), 64'd0);
    chk("R1 alt", 64'(alt_boot), 64'd0);
    chk("R1 timeout", 64'(timeout), 64'd0);
    chk("R1 oe", 64'(ext_oe), 64'd0);
    chk("R1 pin", 64'(ext_pin), 64'd0);
  endtask

  task automatic t_default_sys();
    int k;
    wr(3'd0, 32'd6);
    wr(3'd2, 32'd1);
    run_to_timeout(k);
    chk("R2 first timeout spacing", 64'(k), 64'd7);
    chk("R7 sys pulse", 64'(sys_rst), 64'd1);
    chk("R7 no cpu", 64'(cpu_rst), 64'd0);
    chk("R7 no soc (mask reset to 0)", soc_rst, 64'd0);
    @(negedge clk);
    chk("R7 one clock", 64'(sys_rst), 64'd0);
    k = 1;
    while (!sys_rst && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk("R2 repeat spacing", 64'(k), 64'd7);
    quiesce();
    chk("R13 cleared by disable", 64'(timeout), 64'd0);
  endtask

  task automatic t_tick();
    int n;
    tick = 1'b0;
    wr(3'd0, 32'd4);
    wr(3'd2, 32'd1);
    repeat (30) @(negedge clk);
    chk("R3 no tick no timeout", 64'(timeout), 64'd0);
    n = 0;
    while (n < 100) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      n++;
      if (timeout) break;
      repeat (2) @(negedge clk);
    end
    chk("R3 ticks to timeout", 64'(n), 64'd5);
    tick = 1'b1;
    quiesce();
  endtask

  task automatic t_restart();
    int k;
    wr(3'd0, 32'd10);
    wr(3'd2, 32'd1);
    wr(3'd1, KEY);
    run_to_timeout(k);
    chk("R4 valid restart reloads", 64'(k), 64'd11);
    wr(3'd1, 32'h1234_5678);
    chk("R13 wrong key keeps flag", 64'(timeout), 64'd1);
    wr(3'd1, KEY);
    chk("R13 restart clears flag", 64'(timeout), 64'd0);
    quiesce();
    wr(3'd2, 32'd1);
    wr(3'd1, KEY ^ 32'h1);
    run_to_timeout(k);
    chk("R4 wrong key ignored", 64'(k), 64'd10);
    quiesce();
  endtask

  task automatic t_cpu();
    int k;
    wr(3'd3, ctrl(2'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(3'd0, 32'd5);
    wr(3'd2, 32'd1);
    run_to_timeout(k);
    chk("R5 cpu pulse", 64'(cpu_rst), 64'd1);
    chk("R5 no sys", 64'(sys_rst), 64'd0);
    chk("R5 no soc", soc_rst, 64'd0);
    @(negedge clk);
    chk("R5 one clock", 64'(cpu_rst), 64'd0);
    quiesce();
  endtask

  task automatic t_soc();
    int k;
    wr(3'd5, 32'hF0F0_1234);
    wr(3'd6, 32'h8000_0001);
    wr(3'd3, ctrl(2'd1, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(3'd0, 32'd5);
    wr(3'd2, 32'd1);
    run_to_timeout(k);
    chk("R6 masked soc resets", soc_rst, 64'h8000_0001_F0F0_1234);
    chk("R6 no cpu", 64'(cpu_rst), 64'd0);
    chk("R6 no sys", 64'(sys_rst), 64'd0);
    @(negedge clk);
    chk("R6 one clock", soc_rst, 64'd0);
    quiesce();
  endtask

  task automatic t_none();
    int k, w;
    wr(3'd4, 32'd2);
    wr(3'd3, ctrl(2'd3, 1'b0, 1'b1, 1'b0, 1'b0));
    wr(3'd0, 32'd20);
    wr(3'd2, 32'd1);
    run_to_timeout(k);
    chk("R8 flag still set", 64'(timeout), 64'd1);
    chk("R8 no reset", {cpu_rst, sys_rst, |soc_rst}, 64'd0);
    pulse_len(1'b0, w);
    chk("R8 pulse still emitted", 64'(w), 64'd2);
    quiesce();
  endtask

  task automatic t_pulse();
    int k, w;
    wr(3'd4, 32'd3);
    wr(3'd3, ctrl(2'd3, 1'b0, 1'b1, 1'b0, 1'b0));
    wr(3'd0, 32'd20);
    chk("R11 idle open-drain oe", 64'(ext_oe), 64'd0);
    wr(3'd2, 32'd1);
    run_to_timeout(k);
    chk("R11 open-drain pulls low", 64'(ext_pin), 64'd0);
    pulse_len(1'b0, w);
    chk("R10 width 3", 64'(w), 64'd3);
    chk("R11 released after pulse", 64'(ext_oe), 64'd0);
    quiesce();
    wr(3'd4, 32'd0);
    wr(3'd2, 32'd1);
    run_to_timeout(k);
    pulse_len(1'b0, w);
    chk("R10 width 0 gives one tick", 64'(w), 64'd1);
    quiesce();
    wr(3'd4, 32'd3);
    wr(3'd3, ctrl(2'd3, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(3'd2, 32'd1);
    run_to_timeout(k);
    chk("R10 disabled no pulse", 64'(ext_oe), 64'd0);
    quiesce();
  endtask

  task automatic t_pads();
    int k, w;
    wr(3'd3, ctrl(2'd3, 1'b0, 1'b1, 1'b1, 1'b1));
    chk("R12 pp high idle oe", 64'(ext_oe), 64'd1);
    chk("R12 pp high idle pin", 64'(ext_pin), 64'd0);
    wr(3'd2, 32'd1);
    run_to_timeout(k);
    pulse_len(1'b1, w);
    chk("R12 active-high width", 64'(w), 64'd3);
    chk("R12 back to idle low", 64'(ext_pin), 64'd0);
    quiesce();
    wr(3'd3, ctrl(2'd3, 1'b0, 1'b1, 1'b1, 1'b0));
    chk("R12 pp low idle pin", 64'(ext_pin), 64'd1);
    wr(3'd2, 32'd1);
    run_to_timeout(k);
    pulse_len(1'b0, w);
    chk("R12 active-low width", 64'(w), 64'd3);
    chk("R12 pp low oe held", 64'(ext_oe), 64'd1);
    quiesce();
    wr(3'd3, ctrl(2'd3, 1'b0, 1'b1, 1'b0, 1'b1));
    chk("R12 high w/o pp idle oe", 64'(ext_oe), 64'd0);
    wr(3'd2, 32'd1);
    run_to_timeout(k);
    chk("R12 high w/o pp pin low", 64'(ext_pin), 64'd0);
    pulse_len(1'b0, w);
    chk("R12 high w/o pp width", 64'(w), 64'd3);
    quiesce();
  endtask

  task automatic t_alt();
    int k;
    wr(3'd3, ctrl(2'd3, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(3'd2, 32'd1);
    run_to_timeout(k);
    chk("R9 no request without flag", 64'(alt_boot), 64'd0);
    quiesce();
    wr(3'd3, ctrl(2'd3, 1'b1, 1'b0, 1'b0, 1'b0));
    wr(3'd2, 32'd1);
    run_to_timeout(k);
    chk("R9 request latched", 64'(alt_boot), 64'd1);
    quiesce();
    wr(3'd3, ctrl(2'd3, 1'b0, 1'b0, 1'b0, 1'b0));
    repeat (5) @(negedge clk);
    chk("R9 request held", 64'(alt_boot), 64'd1);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_sys();
    t_tick();
    t_restart();
    t_cpu();
    t_soc();
    t_none();
    t_pulse();
    t_pads();
    t_alt();
    finish_run();
  end
endmodule